// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This unit sits in the branch stage of a SIMD coprocessor pipeline. It takes one decoded 32-bit branch instruction per cycle, together with the program counter, the 128-bit contents of the vector register that the instruction names, and two qualifiers. The first qualifier says whether the instruction occupies a delay or forbidden slot. The second says whether the stricter architecture-release-6 rules are in force. One clock after a valid input, it returns three results: whether the branch is taken, the branch destination, and whether the instruction must instead raise a reserved-instruction exception.

Ten branch encodings are recognised. Two of them test the whole 128-bit value: one is taken when the value is entirely clear, the other when any bit is set. The remaining eight test the value as packed lanes of 8, 16, 32 or 64 bits. One family is taken when some lane is entirely zero, and the other is taken only when every lane holds a nonzero value. Lane detection uses a borrow-propagating subtract-and-mask test on each 64-bit chunk; the chunk results are then OR-combined. For a taken branch the unit also reports the size of the delay slot that follows it. Reading the register file, fetching, flushing and executing the slot all belong to neighbouring blocks.

Top module: `vbr_cond_eval`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `taken`, `rsvd_exc`, `slot_len` and `target` are all zero.
- R2: A request presented with `in_valid` high at a rising edge produces `out_valid` high after that edge, for one cycle per request. Whenever `out_valid` is low, `taken`, `rsvd_exc` and `slot_len` are zero.
- R3: A recognised branch has bits 31:26 equal to 6'b010001. Its sub-op in bits 25:21 is 5'b01011 (whole-value zero), 5'b01111 (whole-value nonzero), 5'b110ff (lane-zero) or 5'b111ff (lane-nonzero). The lane format ff in bits 22:21 is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. Bits 20:16 (register index) do not affect any result.
- R4: The whole-value zero branch is taken exactly when all 128 bits of `vec` are zero.
- R5: The whole-value nonzero branch is taken exactly when at least one bit of `vec` is one.
- R6: The lane-zero branch is taken exactly when at least one lane of the selected width holds all zeros. This holds even when a zero lane sits next to lanes holding 0x80- or 0x01-style patterns, including across the boundary between the two 64-bit halves.
- R7: The lane-nonzero branch is taken exactly when the lane-zero test with the same format would not be taken.
- R8: For every valid request, `target` equals `pc` + 4 + (bits 15:0 sign-extended, times 4), modulo 2^32.
- R9: When `rel6_mode` and `in_slot` are both high on a recognised branch, `rsvd_exc` is 1, `taken` is 0 and `slot_len` is 0. With `rel6_mode` low, `in_slot` has no effect.
- R10: `slot_len` is 4 for a recognised branch that raises no exception, whether taken or not, and 0 otherwise.
- R11: Any other encoding gives `taken`, `rsvd_exc` and `slot_len` all zero, whatever the values of `vec`, `in_slot` and `rel6_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch instruction |
| vec | input | 128 | Contents of the tested vector register |
| in_slot | input | 1 | Instruction sits in a delay or forbidden slot |
| rel6_mode | input | 1 | Release-6 slot rules in force |
| out_valid | output | 1 | Result registers hold a new result |
| taken | output | 1 | Branch condition satisfied |
| target | output | 32 | Branch destination address |
| rsvd_exc | output | 1 | Reserved-instruction exception |
| slot_len | output | 3 | Delay-slot size in bytes (4 or 0) |

## Verification
All five results come out of one register stage, so each one belongs to the rising edge that samples the request. The bench changes inputs on the falling edge and reads every output one time unit after the next rising edge, so each check sees exactly the request sent half a cycle before. The idle check deasserts `in_valid` for one full cycle and reads the outputs after that cycle's rising edge. The lane results are compared against a bit-by-bit loop that walks each lane separately.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

   // Lane width selector carried in instruction bits 22:21
   typedef enum logic [1:0] {
      FMT_BYTE = 2'd0,
      FMT_HALF = 2'd1,
      FMT_WORD = 2'd2,
      FMT_DBL  = 2'd3
   } lane_fmt_e;

   // Decoded condition class
   typedef enum logic [2:0] {
      BOP_NONE     = 3'd0,
      BOP_ALL_ZERO = 3'd1,
      BOP_ANY_SET  = 3'd2,
      BOP_LANE_Z   = 3'd3,
      BOP_LANE_NZ  = 3'd4
   } br_op_e;

   localparam logic [5:0] MAJOR_OPC   = 6'b010001;
   localparam logic [4:0] SUB_ALL_Z   = 5'b01011;
   localparam logic [4:0] SUB_ANY_SET = 5'b01111;
   localparam logic [2:0] SUB_LANE_Z  = 3'b110;
   localparam logic [2:0] SUB_LANE_NZ = 3'b111;

   localparam int NUM_FMT   = 4;
   localparam int SLOT_W    = 3;
   localparam int SLOT_SIZE = 4;

endpackage

// File: rtl/vbr_decode.sv
module vbr_decode
   import vbr_pkg::*;
(
   input  logic [10:0] opc_bits,   // instruction bits 31:21
   input  logic [15:0] imm_bits,   // instruction bits 15:0
   output br_op_e      op,
   output lane_fmt_e   fmt,
   output logic [15:0] offset
);

   logic [5:0] major;
   logic [4:0] sub;

   assign major  = opc_bits[10:5];
   assign sub    = opc_bits[4:0];
   assign fmt    = lane_fmt_e'(sub[1:0]);
   assign offset = imm_bits;

   always_comb begin
      op = BOP_NONE;
      if (major == MAJOR_OPC) begin
         if (sub == SUB_ALL_Z)
            op = BOP_ALL_ZERO;
         else if (sub == SUB_ANY_SET)
            op = BOP_ANY_SET;
         else if (sub[4:2] == SUB_LANE_Z)
            op = BOP_LANE_Z;
         else if (sub[4:2] == SUB_LANE_NZ)
            op = BOP_LANE_NZ;
      end
   end

endmodule

// File: rtl/vbr_zero_lane.sv
module vbr_zero_lane
   import vbr_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int CHUNK_W = 64
) (
   input  logic [VEC_W-1:0]   vec,
   output logic [NUM_FMT-1:0] any_zero   // one bit per lane format
);

   localparam int NCHUNK = VEC_W / CHUNK_W;

   // Pattern with a one at bit position 'pos' of every lane of width 'lw'
   function automatic logic [CHUNK_W-1:0] lane_pattern(input int lw, input int pos);
      logic [CHUNK_W-1:0] r;
      for (int i = 0; i < CHUNK_W; i++)
         r[i] = ((i % lw) == pos);
      return r;
   endfunction

   if (CHUNK_W < 64 || (CHUNK_W & (CHUNK_W - 1)) != 0) begin : g_bad_chunk
      $error("vbr_zero_lane: CHUNK_W must be a power of two of at least 64");
   end
   if (VEC_W < CHUNK_W || (VEC_W % CHUNK_W) != 0) begin : g_bad_vec
      $error("vbr_zero_lane: VEC_W must be a multiple of CHUNK_W");
   end

   for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
      localparam int                 LW    = 8 << f;
      localparam logic [CHUNK_W-1:0] LSB_P = lane_pattern(LW, 0);
      localparam logic [CHUNK_W-1:0] MSB_P = lane_pattern(LW, LW - 1);

      logic [NCHUNK-1:0] chunk_hit;

      for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
         logic [CHUNK_W-1:0] word;
         logic [CHUNK_W-1:0] borrow;
         assign word         = vec[c*CHUNK_W +: CHUNK_W];
         assign borrow       = word - LSB_P;
         assign chunk_hit[c] = |(borrow & ~word & MSB_P);
      end

      assign any_zero[f] = |chunk_hit;
   end

endmodule

// File: rtl/vbr_target.sv
module vbr_target #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [15:0]       offset,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - 18;

   if (ADDR_W < 19) begin : g_bad_addr
      $error("vbr_target: ADDR_W must be at least 19");
   end

   logic [ADDR_W-1:0] disp;

   assign disp   = {{EXT_W{offset[15]}}, offset, 2'b00};
   assign target = pc + disp + ADDR_W'(4);

endmodule

// File: rtl/vbr_cond_eval.sv
module vbr_cond_eval
   import vbr_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int CHUNK_W = 64,
   parameter int ADDR_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [31:0]         instr,
   input  logic [ADDR_W-1:0]   pc,
   input  logic [VEC_W-1:0]    vec,
   input  logic                in_slot,
   input  logic                rel6_mode,
   output logic                out_valid,
   output logic                taken,
   output logic [ADDR_W-1:0]   target,
   output logic                rsvd_exc,
   output logic [SLOT_W-1:0]   slot_len
);

   br_op_e              op;
   lane_fmt_e           fmt;
   logic [15:0]         offset;
   logic [NUM_FMT-1:0]  any_zero;
   logic [ADDR_W-1:0]   tgt_next;
   logic                recog;
   logic                exc_next;
   logic                cond;
   logic                unused_reg_idx;

   assign unused_reg_idx = ^instr[20:16];

   vbr_decode u_decode (
      .opc_bits (instr[31:21]),
      .imm_bits (instr[15:0]),
      .op       (op),
      .fmt      (fmt),
      .offset   (offset)
   );

   vbr_zero_lane #(
      .VEC_W   (VEC_W),
      .CHUNK_W (CHUNK_W)
   ) u_zero_lane (
      .vec      (vec),
      .any_zero (any_zero)
   );

   vbr_target #(
      .ADDR_W (ADDR_W)
   ) u_target (
      .pc     (pc),
      .offset (offset),
      .target (tgt_next)
   );

   assign recog    = (op != BOP_NONE);
   assign exc_next = recog && rel6_mode && in_slot;

   always_comb begin
      unique case (op)
         BOP_ALL_ZERO: cond = ~|vec;
         BOP_ANY_SET:  cond = |vec;
         BOP_LANE_Z:   cond = any_zero[fmt];
         BOP_LANE_NZ:  cond = ~any_zero[fmt];
         default:      cond = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         rsvd_exc  <= 1'b0;
         slot_len  <= '0;
         target    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            taken    <= cond && !exc_next;
            rsvd_exc <= exc_next;
            slot_len <= (recog && !exc_next) ? SLOT_W'(SLOT_SIZE) : '0;
            target   <= tgt_next;
         end else begin
            taken    <= 1'b0;
            rsvd_exc <= 1'b0;
            slot_len <= '0;
         end
      end
   end

endmodule

// File: rtl/vbr_cond_eval_chk.sv
module vbr_cond_eval_chk
   import vbr_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int ADDR_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [31:0]         instr,
   input logic [ADDR_W-1:0]   pc,
   input logic [VEC_W-1:0]    vec,
   input logic                in_slot,
   input logic                rel6_mode,
   input logic                out_valid,
   input logic                taken,
   input logic [ADDR_W-1:0]   target,
   input logic                rsvd_exc,
   input logic [SLOT_W-1:0]   slot_len
);

   logic              c_major;
   logic              c_all_z;
   logic              c_any_set;
   logic              c_known;
   logic [ADDR_W-1:0] c_tgt;

   assign c_major   = (instr[31:26] == MAJOR_OPC);
   assign c_all_z   = c_major && (instr[25:21] == SUB_ALL_Z);
   assign c_any_set = c_major && (instr[25:21] == SUB_ANY_SET);
   assign c_known   = c_all_z || c_any_set || (c_major && instr[25:24] == 2'b11);
   assign c_tgt     = pc + ADDR_W'(4) + {{(ADDR_W-18){instr[15]}}, instr[15:0], 2'b00};

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!taken && !rsvd_exc && slot_len == '0)); // R2
   AST_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_all_z && !(rel6_mode && in_slot)) |=> (taken == $past(vec == '0))); // R4
   AST_ANY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_any_set && !(rel6_mode && in_slot)) |=> (taken == $past(vec != '0))); // R5
   AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (target == $past(c_tgt))); // R8
   AST_SLOT_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_known && rel6_mode && in_slot) |=> (rsvd_exc && !taken)); // R9
   AST_SLOT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> (slot_len == SLOT_W'(SLOT_SIZE))); // R10
   AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !c_known) |=> (!taken && !rsvd_exc && slot_len == '0)); // R11

endmodule

bind vbr_cond_eval vbr_cond_eval_chk #(
   .VEC_W  (VEC_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .pc        (pc),
   .vec       (vec),
   .in_slot   (in_slot),
   .rel6_mode (rel6_mode),
   .out_valid (out_valid),
   .taken     (taken),
   .target    (target),
   .rsvd_exc  (rsvd_exc),
   .slot_len  (slot_len)
);

// File: tb/test_vbr_cond_eval.sv
`timescale 1ns/1ps
module test_vbr_cond_eval;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [31:0]  pc = '0;
   logic [127:0] vec = '0;
   logic         in_slot = 1'b0;
   logic         rel6_mode = 1'b0;
   logic         out_valid;
   logic         taken;
   logic [31:0]  target;
   logic         rsvd_exc;
   logic [2:0]   slot_len;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   vbr_cond_eval i_vbr_cond_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .pc        (pc),
      .vec       (vec),
      .in_slot   (in_slot),
      .rel6_mode (rel6_mode),
      .out_valid (out_valid),
      .taken     (taken),
      .target    (target),
      .rsvd_exc  (rsvd_exc),
      .slot_len  (slot_len)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   // ---------------- reference model ----------------
   function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] idx,
                                      input logic [15:0] imm);
      return {6'b010001, sub, idx, imm};
   endfunction

   function automatic bit ref_lane_zero(input logic [127:0] v, input int fmt);
      int lw = 8 << fmt;
      for (int l = 0; l < 128 / lw; l++) begin
         bit z = 1'b1;
         for (int b = 0; b < lw; b++)
            if (v[l*lw + b]) z = 1'b0;
         if (z) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic logic [127:0] fill(input int fmt, input logic [63:0] val);
      logic [127:0] r = '0;
      int lw = 8 << fmt;
      for (int l = 0; l < 128 / lw; l++)
         for (int b = 0; b < lw; b++)
            r[l*lw + b] = val[b];
      return r;
   endfunction

   function automatic logic [127:0] clear_lane(input logic [127:0] v, input int fmt, input int lane);
      logic [127:0] r = v;
      int lw = 8 << fmt;
      for (int b = 0; b < lw; b++)
         r[lane*lw + b] = 1'b0;
      return r;
   endfunction

   // Drive at the falling edge; results are read 1 ns after the next rising edge
   task automatic issue(input logic [31:0] i, input logic [31:0] p, input logic [127:0] v,
                        input logic s, input logic r6);
      @(negedge clk);
      in_valid  = 1'b1;
      instr     = i;
      pc        = p;
      vec       = v;
      in_slot   = s;
      rel6_mode = r6;
      @(posedge clk);
      #1;
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic lane_case(input int fmt, input logic [127:0] v, input string tag);
      logic exp_z = ref_lane_zero(v, fmt);
      issue(mk({3'b110, 2'(fmt)}, 5'd7, 16'h0010), 32'h0000_1000, v, 1'b0, 1'b0);
      check({"R6 lane-zero ", tag}, taken, exp_z);
      check("R10 slot length", slot_len, 3'd4);
      issue(mk({3'b111, 2'(fmt)}, 5'd7, 16'h0010), 32'h0000_1000, v, 1'b0, 1'b0);
      check({"R7 lane-nonzero ", tag}, taken, !exp_z);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = 1'b1;
      instr = mk(5'b01011, 5'd0, 16'h0001);
      vec = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 out_valid in reset", out_valid, 1'b0);
      check("R1 taken in reset", taken, 1'b0);
      check("R1 rsvd_exc in reset", rsvd_exc, 1'b0);
      check("R1 slot_len in reset", slot_len, 3'd0);
      check("R1 target in reset", target, 32'd0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_timing();
      issue(mk(5'b01111, 5'd1, 16'h0000), 32'h100, 128'h1, 1'b0, 1'b0);
      check("R2 out_valid after request", out_valid, 1'b1);
      check("R2 taken after request", taken, 1'b1);
      go_idle();
      @(posedge clk);
      #1;
      check("R2 out_valid when idle", out_valid, 1'b0);
      check("R2 taken when idle", taken, 1'b0);
      check("R2 slot_len when idle", slot_len, 3'd0);
   endtask

   task automatic t_whole();
      logic [127:0] pats [5] = '{128'h0, 128'h1, {1'b1, 127'h0},
                                 {64'h0000_0000_0000_0001, 64'h0}, ~128'h0};
      foreach (pats[k]) begin
         issue(mk(5'b01011, 5'd2, 16'h0004), 32'h2000, pats[k], 1'b0, 1'b0);
         check("R4 whole-value zero", taken, pats[k] == '0);
         issue(mk(5'b01111, 5'd2, 16'h0004), 32'h2000, pats[k], 1'b0, 1'b0);
         check("R5 whole-value nonzero", taken, pats[k] != '0);
      end
   endtask

   task automatic t_lanes_directed();
      for (int f = 0; f < 4; f++) begin
         lane_case(f, fill(f, 64'h8080_8080_8080_8080), "all msb");
         lane_case(f, clear_lane(fill(f, 64'h8080_8080_8080_8080), f, 1), "msb next to zero");
         lane_case(f, fill(f, 64'h0101_0101_0101_0101), "all lsb-ones");
         lane_case(f, clear_lane(fill(f, 64'h1), f, 0), "one above zero lane");
         lane_case(f, clear_lane(fill(f, 64'h1), f, (64 >> (f + 3)) - 1), "zero at half top");
         lane_case(f, clear_lane(fill(f, 64'h1), f, (128 >> (f + 3)) - 1), "zero at top lane");
         lane_case(f, '0, "all zero");
      end
      // byte zero inside nonzero halfwords and words
      lane_case(0, fill(1, 64'h0100), "byte hole");
      lane_case(1, fill(1, 64'h0100), "half no hole");
      lane_case(2, fill(2, 64'h0000_8000), "word msb");
      lane_case(3, {64'h1, 64'h0}, "low dword zero");
      lane_case(3, {64'h8000_0000_0000_0000, 64'h1}, "no dword zero");
   endtask

   task automatic t_lanes_random();
      for (int n = 0; n < 300; n++) begin
         int f = n % 4;
         logic [127:0] v = {$urandom, $urandom, $urandom, $urandom};
         if (n % 3 == 0) v = clear_lane(v, f, $urandom % (128 >> (f + 3)));
         if (n % 5 == 0) v = v & fill(f, 64'h0101_0101_0101_0101);
         lane_case(f, v, "random");
      end
   endtask

   task automatic t_target();
      logic [15:0] imms [5] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff};
      logic [31:0] pcs  [5] = '{32'h0000_0000, 32'h0040_0100, 32'hffff_fffc, 32'h0000_0004, 32'h8000_0000};
      foreach (imms[k]) begin
         logic [31:0] exp = pcs[k] + 32'd4 + {{14{imms[k][15]}}, imms[k], 2'b00};
         issue(mk(5'b11010, 5'd9, imms[k]), pcs[k], 128'h5, 1'b0, 1'b0);
         check("R8 target", target, exp);
      end
      issue(mk(5'b00000, 5'd0, 16'hfffe), 32'h10, 128'h0, 1'b0, 1'b0);
      check("R8 target on other encoding", target, 32'h10 + 32'd4 - 32'd8);
   endtask

   task automatic t_slot();
      issue(mk(5'b01011, 5'd3, 16'h0002), 32'h300, 128'h0, 1'b1, 1'b1);
      check("R9 exception raised", rsvd_exc, 1'b1);
      check("R9 taken suppressed", taken, 1'b0);
      check("R9 slot_len cleared", slot_len, 3'd0);
      issue(mk(5'b11100, 5'd3, 16'h0002), 32'h300, 128'h1, 1'b1, 1'b1);
      check("R9 exception on lane branch", rsvd_exc, 1'b1);
      check("R9 taken suppressed lane", taken, 1'b0);
      issue(mk(5'b01011, 5'd3, 16'h0002), 32'h300, 128'h0, 1'b1, 1'b0);
      check("R9 slot ignored without rel6", rsvd_exc, 1'b0);
      check("R9 taken without rel6", taken, 1'b1);
      issue(mk(5'b01011, 5'd3, 16'h0002), 32'h300, 128'h0, 1'b0, 1'b1);
      check("R9 rel6 outside slot", rsvd_exc, 1'b0);
      check("R10 slot_len not-slot", slot_len, 3'd4);
      issue(mk(5'b01111, 5'd3, 16'h0002), 32'h300, 128'h0, 1'b0, 1'b0);
      check("R10 slot_len not taken", slot_len, 3'd4);
   endtask

   task automatic t_bad_ops();
      logic [31:0] bad [6] = '{
         {6'b010000, 5'b01011, 5'd0, 16'h0},
         {6'b010001, 5'b01010, 5'd0, 16'h0},
         {6'b010001, 5'b10000, 5'd0, 16'h0},
         {6'b010001, 5'b01110, 5'd0, 16'h0},
         {6'b110001, 5'b11100, 5'd0, 16'h0},
         32'h0};
      foreach (bad[k]) begin
         issue(bad[k], 32'h400, '0, 1'b1, 1'b1);
         check("R11 other encoding taken", taken, 1'b0);
         check("R11 other encoding exception", rsvd_exc, 1'b0);
         check("R11 other encoding slot_len", slot_len, 3'd0);
      end
   endtask

   task automatic t_index_ignored();
      for (int i = 0; i < 32; i += 31) begin
         issue(mk(5'b11000, 5'(i), 16'h0), 32'h0, fill(0, 64'h1), 1'b0, 1'b0);
         check("R3 register index ignored", taken, 1'b0);
         issue(mk(5'b11100, 5'(i), 16'h0), 32'h0, fill(0, 64'h1), 1'b0, 1'b0);
         check("R3 register index ignored nz", taken, 1'b1);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_timing();
      t_whole();
      t_lanes_directed();
      t_lanes_random();
      t_target();
      t_slot();
      t_bad_ops();
      t_index_ignored();
      go_idle();
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule